// File: doc/BRIEF.md
# Ingress Cell Receiver

This block terminates a single ingress port of a cell switch. The port runs on its own clock, anywhere from 10 MHz to 100 MHz, unrelated to the system clock. Each port clock carries one byte, a parity bit and a start-of-cell flag. The block frames 56-byte cells, checks odd parity on every byte and builds a CRC-8 over each cell. It then hands the whole cell, its CRC and an error flag to the system clock domain through a two-entry buffer.

The block reports three conditions in the system domain. A one-cycle pulse marks a framing fault. A one-cycle pulse marks an overrun, where a cell arrives while both buffer entries still hold undelivered cells. A level flags a port clock that has stopped. Software must enable the port before any cell is accepted. The consumer sees a held cell on a wide bus and removes it with a one-cycle take strobe.

Top module: `ingress_cell_rx`

## Requirements
- R1: After reset, out_valid, frm_err, ovr_err and clk_lost are all 0.
- R2: While port_en is 0, cells on the port are ignored and out_valid stays 0.
- R3: A cell is 56 bytes starting at the byte with rx_soc set; byte k of the cell appears on out_cell bits [8k+7:8k].
- R4: out_crc is the CRC-8 of the cell's 56 bytes, polynomial x^8+x^2+x+1 (0x07), initial value 0x00, each byte fed most significant bit first, no final inversion.
- R5: Parity is odd over the 9 bits rx_data and rx_par. A cell holding any byte with an even count of ones is still delivered, with out_perr set to 1. Otherwise out_perr is 0.
- R6: A start-of-cell flag in the middle of a cell drops the partial cell, gives one frm_err pulse, and begins a new cell at that byte.
- R7: A cell that starts while both buffer entries are occupied is discarded and gives one ovr_err pulse. The two held cells are delivered intact and in order.
- R8: Once out_valid is 1, it stays 1 with out_cell, out_crc and out_perr unchanged until out_take is 1. Cells leave in arrival order, one per take.
- R9: clk_lost goes to 1 when no port clock activity is seen for 64 system clocks. It returns to 0 soon after the port clock resumes.
- R10: Bytes that arrive with rx_soc at 0 while no cell is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| port_en | input | 1 | Software enable for the port |
| prt_clk | input | 1 | Port clock |
| prt_rst_n | input | 1 | Active-low asynchronous reset, port domain |
| rx_data | input | 8 | Port data byte |
| rx_par | input | 1 | Odd parity bit for rx_data |
| rx_soc | input | 1 | Marks byte 0 of a cell |
| out_valid | output | 1 | A complete cell is held for the consumer |
| out_cell | output | 448 | Held cell, byte 0 in the low bits |
| out_crc | output | 8 | CRC-8 of the held cell |
| out_perr | output | 1 | The held cell carried a parity error |
| out_take | input | 1 | Consumer removes the held cell |
| frm_err | output | 1 | One-cycle pulse on a mid-cell start flag |
| ovr_err | output | 1 | One-cycle pulse on a discarded cell |
| clk_lost | output | 1 | Port clock activity missing |

## Verification
The hardest state to reach from the ports is an overrun that relies on the synchronised read pointer showing a full buffer. The stimulus reaches it by withholding out_take while three back-to-back cells arrive. It then drains the buffer and compares both surviving cells to their expected contents. Clock loss is driven by gating the bench's port clock, and the flag is sampled both well inside the 64-cycle window and after it. A mid-cell start flag is produced by cutting a cell short and opening a new one.

// File: rtl/ingress_cell_rx.sv
module ingress_cell_rx #(
  parameter int CELL_BYTES  = 56,
  parameter int LOSS_CYCLES = 64,
  parameter logic [7:0] CRC_POLY = 8'h07
) (
  input  logic                    sys_clk,
  input  logic                    sys_rst_n,
  input  logic                    port_en,
  input  logic                    prt_clk,
  input  logic                    prt_rst_n,
  input  logic [7:0]              rx_data,
  input  logic                    rx_par,
  input  logic                    rx_soc,
  output logic                    out_valid,
  output logic [CELL_BYTES*8-1:0] out_cell,
  output logic [7:0]              out_crc,
  output logic                    out_perr,
  input  logic                    out_take,
  output logic                    frm_err,
  output logic                    ovr_err,
  output logic                    clk_lost
);

  localparam int CW = $clog2(CELL_BYTES);
  localparam int LW = $clog2(LOSS_CYCLES + 1);
  localparam int CB = CELL_BYTES * 8;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    return r;
  endfunction

  // port-domain state
  logic [1:0]    en_s, wb, wg, rg_s1, rg_s2;
  logic [CW-1:0] cnt;
  logic          active, pe_q, frm_tg, ovr_tg, prt_tg;
  logic [7:0]    crc_q;
  logic [CB-1:0] cell_mem [2];
  logic [7:0]    crc_mem  [2];
  logic          pe_mem   [2];

  // system-domain state
  logic [1:0]    rb, rg, wg_s1, wg_s2;
  logic [2:0]    tg_s, fr_s, ov_s;
  logic [LW-1:0] lcnt;

  wire          byte_bad = ~^{rx_data, rx_par};
  wire [1:0]    rb_p     = {rg_s2[1], ^rg_s2};
  wire          full_p   = (wb - rb_p) == 2'd2;
  wire          last_b   = active && !rx_soc && (cnt == CW'(CELL_BYTES - 1));
  wire          take_b   = en_s[1] && (rx_soc ? !full_p : active);
  wire [7:0]    crc_n    = crc_step(rx_soc ? 8'h00 : crc_q, rx_data);
  wire          pe_n     = byte_bad | (!rx_soc & pe_q);
  wire [CW-1:0] cnt_w    = rx_soc ? '0 : cnt;
  wire [1:0]    wb_n     = wb + 2'd1;

  always_ff @(posedge prt_clk or negedge prt_rst_n)
    if (!prt_rst_n) begin
      en_s <= '0; wb <= '0; wg <= '0; rg_s1 <= '0; rg_s2 <= '0;
      cnt <= '0; active <= 1'b0; pe_q <= 1'b0; crc_q <= '0;
      frm_tg <= 1'b0; ovr_tg <= 1'b0; prt_tg <= 1'b0;
    end else begin
      en_s   <= {en_s[0], port_en};
      rg_s1  <= rg;
      rg_s2  <= rg_s1;
      prt_tg <= ~prt_tg;
      if (!en_s[1]) active <= 1'b0;
      else if (rx_soc) begin
        if (active) frm_tg <= ~frm_tg;
        if (full_p) begin
          ovr_tg <= ~ovr_tg;
          active <= 1'b0;
        end else begin
          active <= 1'b1;
          cnt    <= CW'(1);
          crc_q  <= crc_n;
          pe_q   <= pe_n;
        end
      end else if (active) begin
        crc_q <= crc_n;
        pe_q  <= pe_n;
        cnt   <= cnt + 1'b1;
        if (last_b) begin
          active <= 1'b0;
          wb     <= wb_n;
          wg     <= wb_n ^ (wb_n >> 1);
        end
      end
    end

  always_ff @(posedge prt_clk)
    if (take_b) begin
      cell_mem[wb[0]][{cnt_w, 3'b000} +: 8] <= rx_data;
      if (last_b) begin
        crc_mem[wb[0]] <= crc_n;
        pe_mem[wb[0]]  <= pe_n;
      end
    end

  // R7
  no_overfill_chk: assert property (@(posedge prt_clk) disable iff (!prt_rst_n)
    (wb - rb_p) != 2'd3);

  wire [1:0] wb_s   = {wg_s2[1], ^wg_s2};
  wire       pop    = out_valid && out_take;
  wire [1:0] rb_n   = rb + 2'd1;
  wire       tg_edge = tg_s[2] ^ tg_s[1];

  assign out_valid = rb != wb_s;
  assign out_cell  = cell_mem[rb[0]];
  assign out_crc   = crc_mem[rb[0]];
  assign out_perr  = pe_mem[rb[0]];
  assign frm_err   = fr_s[2] ^ fr_s[1];
  assign ovr_err   = ov_s[2] ^ ov_s[1];
  assign clk_lost  = lcnt == LW'(LOSS_CYCLES);

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      rb <= '0; rg <= '0; wg_s1 <= '0; wg_s2 <= '0;
      tg_s <= '0; fr_s <= '0; ov_s <= '0; lcnt <= '0;
    end else begin
      wg_s1 <= wg;
      wg_s2 <= wg_s1;
      tg_s  <= {tg_s[1:0], prt_tg};
      fr_s  <= {fr_s[1:0], frm_tg};
      ov_s  <= {ov_s[1:0], ovr_tg};
      if (pop) begin
        rb <= rb_n;
        rg <= rb_n ^ (rb_n >> 1);
      end
      if (tg_edge) lcnt <= '0;
      else if (!clk_lost) lcnt <= lcnt + 1'b1;
    end

  // R8
  hold_valid_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    out_valid && !out_take |=> out_valid && $stable(out_cell) && $stable(out_crc) && $stable(out_perr));

  // R8
  no_spurious_pop_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    !(out_valid && out_take) |=> $stable(rb));

  // R9
  lost_clear_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    tg_edge |=> !clk_lost);

  // R9
  lost_bound_chk: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    lcnt <= LW'(LOSS_CYCLES));

endmodule

// File: tb/ingress_cell_rx_tb.sv
module ingress_cell_rx_tb;
  localparam int NB = 56;

  logic sys_clk = 0, prt_clk = 0, prt_run = 1;
  logic sys_rst_n = 0, prt_rst_n = 0, port_en = 0;
  logic [7:0] rx_data = 0;
  logic rx_par = 0, rx_soc = 0, out_take = 0;
  logic out_valid, out_perr, frm_err, ovr_err, clk_lost;
  logic [NB*8-1:0] out_cell;
  logic [7:0] out_crc;

  int total = 0, fails = 0, frm_n = 0, ovr_n = 0;
  bit done = 0;

  ingress_cell_rx u_dut (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .port_en(port_en),
    .prt_clk(prt_clk), .prt_rst_n(prt_rst_n), .rx_data(rx_data), .rx_par(rx_par), .rx_soc(rx_soc),
    .out_valid(out_valid), .out_cell(out_cell), .out_crc(out_crc), .out_perr(out_perr),
    .out_take(out_take), .frm_err(frm_err), .ovr_err(ovr_err), .clk_lost(clk_lost));

  always #2 sys_clk = ~sys_clk;
  always #5 prt_clk = prt_run ? ~prt_clk : prt_clk;

  always @(negedge sys_clk) begin
    if (frm_err) frm_n++;
    if (ovr_err) ovr_n++;
  end

  // {seed, bad byte index (FF = none), expected parity flag}
  localparam logic [16:0] VEC [5] = '{
    {8'h00, 8'hFF, 1'b0}, {8'h3C, 8'hFF, 1'b0}, {8'h77, 8'd0, 1'b1},
    {8'hC1, 8'd55, 1'b1}, {8'hFF, 8'd20, 1'b1}};

  function automatic logic [7:0] cbyte(input logic [7:0] seed, input int k);
    return seed + 8'(k * 29);
  endfunction

  function automatic logic [NB*8-1:0] exp_cell(input logic [7:0] seed);
    logic [NB*8-1:0] r;
    for (int k = 0; k < NB; k++) r[k*8 +: 8] = cbyte(seed, k);
    return r;
  endfunction

  function automatic logic [7:0] exp_crc(input logic [7:0] seed);
    logic [7:0] c = 8'h00;
    for (int k = 0; k < NB; k++) begin
      logic [7:0] d = cbyte(seed, k);
      for (int b = 7; b >= 0; b--) begin
        logic fb = c[7] ^ d[b];
        c = {c[6:0], 1'b0};
        if (fb) c = c ^ 8'h07;
      end
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NB*8-1:0] act, input logic [NB*8-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_cell(input logic [7:0] seed, input int bad, input int nbytes);
    for (int k = 0; k < nbytes; k++) begin
      @(negedge prt_clk);
      rx_data = cbyte(seed, k);
      rx_soc  = (k == 0);
      rx_par  = (~^rx_data) ^ (k == bad);
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge prt_clk);
      rx_soc = 0; rx_data = 8'hA5; rx_par = 0;
    end
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 400; i++) begin
      @(negedge sys_clk);
      if (out_valid) break;
    end
  endtask

  task automatic take();
    out_take = 1;
    @(negedge sys_clk);
    out_take = 0;
  endtask

  task automatic get_cell(input logic [7:0] seed, input bit perr, input string req);
    wait_valid();
    chk(out_valid == 1, {req, " valid"}, out_valid, 1);
    chk(out_cell == exp_cell(seed), {req, " R3 cell bytes"}, out_cell, exp_cell(seed));
    chk(out_crc == exp_crc(seed), {req, " R4 crc"}, out_crc, exp_crc(seed));
    chk(out_perr == perr, {req, " R5 perr"}, out_perr, perr);
    take();
  endtask

  initial begin
    repeat (150000) @(posedge sys_clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL R8 watchdog act=hung exp=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [NB*8-1:0] held;
    int f0, o0;
    repeat (10) @(negedge sys_clk);
    sys_rst_n = 1; prt_rst_n = 1;
    @(negedge sys_clk);
    // R1
    chk(!out_valid && !frm_err && !ovr_err && !clk_lost, "R1 reset outputs",
        {out_valid, frm_err, ovr_err, clk_lost}, 0);

    // R2: disabled port
    send_cell(8'h11, -1, NB);
    repeat (200) @(negedge sys_clk);
    chk(out_valid == 0, "R2 disabled port ignored", out_valid, 0);
    port_en = 1;
    repeat (10) @(negedge prt_clk);

    // R10: stray bytes outside any cell, then a clean cell
    for (int k = 0; k < 20; k++) begin
      @(negedge prt_clk);
      rx_soc = 0; rx_data = 8'(k * 7); rx_par = 0;
    end
    send_cell(8'h5A, -1, NB);
    get_cell(8'h5A, 0, "R10 stray bytes ignored");

    // table: R3 R4 R5
    for (int i = 0; i < 5; i++) begin
      send_cell(VEC[i][16:9], (VEC[i][8:1] == 8'hFF) ? -1 : int'(VEC[i][8:1]), NB);
      get_cell(VEC[i][16:9], VEC[i][0], "R5 vector");
    end

    // R6: framing abort
    f0 = frm_n;
    send_cell(8'h21, -1, 10);
    send_cell(8'h42, -1, NB);
    get_cell(8'h42, 0, "R6 cell after abort");
    repeat (30) @(negedge sys_clk);
    chk(frm_n - f0 == 1, "R6 frm_err pulses", frm_n - f0, 1);
    chk(out_valid == 0, "R6 partial cell dropped", out_valid, 0);

    // R7 and R8: overrun with held cells
    o0 = ovr_n;
    send_cell(8'hA1, -1, NB);
    send_cell(8'hB2, -1, NB);
    send_cell(8'hC3, -1, NB);
    repeat (30) @(negedge sys_clk);
    chk(ovr_n - o0 == 1, "R7 ovr_err pulses", ovr_n - o0, 1);
    held = out_cell;
    repeat (40) @(negedge sys_clk);
    chk(out_valid == 1 && out_cell == held, "R8 held cell stable", out_cell, held);
    get_cell(8'hA1, 0, "R7 first held");
    get_cell(8'hB2, 0, "R7 second held");
    repeat (60) @(negedge sys_clk);
    chk(out_valid == 0, "R7 discarded cell absent", out_valid, 0);

    // R9: clock loss
    @(negedge prt_clk);
    prt_run = 0;
    repeat (30) @(negedge sys_clk);
    chk(clk_lost == 0, "R9 not lost inside window", clk_lost, 0);
    repeat (60) @(negedge sys_clk);
    chk(clk_lost == 1, "R9 lost after window", clk_lost, 1);
    prt_run = 1;
    repeat (12) @(negedge sys_clk);
    chk(clk_lost == 0, "R9 cleared on resume", clk_lost, 0);
    repeat (10) @(negedge prt_clk);
    send_cell(8'h99, 3, NB);
    get_cell(8'h99, 1, "R9 recovery cell");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule